// File: doc/BRIEF.md
# Thread-Partitioned Instruction Fetch Buffer

This block sits between instruction fetch and decode in a core that can run one, two, four or eight hardware threads. It stores fetched instruction words in one shared storage array of twice the single-thread capacity. A two-bit threading mode cuts that array into equal private circular queues, one per active thread. Every queue keeps its own head pointer, tail pointer and occupancy count. Because the queues are private, a thread that stalls with a full queue never takes entries from a neighbour.

Fetch supplies one tagged instruction word per cycle. The tag selects the destination thread. Each thread has its own read-enable bit and a show-ahead read word, so decode sees the oldest entry of every thread at the same time. Each thread also reports full, empty and count. The mode may only change while every queue is empty. A prefetch-enable output is switched off in the densest mode to save fetch bandwidth.

Top module: `smt_fetch_buf`

## Requirements
- R1: After a synchronous active-low reset, the mode is 0, every thread reports empty, none reports full, every count is 0, prefetch-enable is high and the error flag is low.
- R2: Each mode code sets the number of active threads and the size of each thread's queue. Code 0 gives thread 0 only, with 64 entries. Code 1 gives threads 0 and 1, with 64 entries each. Code 2 gives threads 0 to 3, with 32 entries each. Code 3 gives threads 0 to 7, with 16 entries each. A thread's full flag rises exactly when its count equals its queue size.
- R3: Each thread's read word always shows that thread's oldest stored entry while the thread is not empty. Asserting the thread's read-enable bit removes that entry one cycle later, and entries leave in the order they were written.
- R4: A full thread does not prevent writes to any other thread, and data written to one thread never shows up in another thread's queue.
- R5: A write to a full thread is dropped. The count stays the same and the stored entries are not overwritten.
- R6: A write whose thread tag is not active in the current mode is dropped, and the error flag is high for exactly the one following cycle.
- R7: A read-enable on an empty thread has no effect. The count stays 0, and later writes and reads on that thread behave normally.
- R8: A read and a write to the same non-empty, non-full thread in the same cycle leave its count unchanged and keep first-in, first-out order.
- R9: A mode request is accepted only if every queue is empty and no write is presented in that cycle. The new mode is visible one cycle later. Any other request is ignored and the current mode is kept.
- R10: Prefetch-enable is low only while the mode is 3.
- R11: A thread that is not active in the current mode reports empty, not full, and a count of 0.
- R12: Each queue is circular. After the pointers wrap past the end of the region, the queue still fills to its full size and drains in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req_i | input | 2 | Requested threading mode code |
| mode_req_vld_i | input | 1 | Mode change request strobe |
| mode_o | output | 2 | Current threading mode code |
| prefetch_en_o | output | 1 | Prefetch allowed (low in mode 3) |
| wr_vld_i | input | 1 | Instruction word write valid |
| wr_tid_i | input | 3 | Destination thread of the write |
| wr_data_i | input | WORD_W | Instruction word to store |
| wr_err_o | output | 1 | One-cycle pulse after a write to an inactive thread |
| rd_en_i | input | 8 | Per-thread read (pop) enable |
| rd_data_o | output | 8*WORD_W | Per-thread oldest word, thread t in bits [t*WORD_W +: WORD_W] |
| full_o | output | 8 | Per-thread full flag |
| empty_o | output | 8 | Per-thread empty flag |
| count_o | output | 8*CNT_W | Per-thread occupancy, thread t in bits [t*CNT_W +: CNT_W] |

## Verification
The queues are tried in every mode with several write patterns. Filling one thread to capacity shows the queue size of each mode. A burst to one thread while a neighbour is full shows that the queues are isolated. Writes that wrap the pointers of a small queue show that the region base and the wrap point are right. A cycle with a read and a write on the same thread separates correct count bookkeeping from off-by-one slips. Writes with inactive tags, and mode requests made while data is still held or while a write is in flight, show that illegal traffic is dropped and leaves no trace.

// File: rtl/smt_fb_pkg.sv
// Shared types and mode-derived sizing for the thread-partitioned fetch buffer.
// Assumes exactly four threading modes and at most eight threads.
package smt_fb_pkg;

    localparam int unsigned THR_MAX = 8;
    localparam int unsigned TID_W   = 3;

    typedef enum logic [1:0] {
        MODE_ST   = 2'd0,
        MODE_SMT2 = 2'd1,
        MODE_SMT4 = 2'd2,
        MODE_SMT8 = 2'd3
    } fb_mode_e;

    // Entries in one thread's private queue for a given mode.
    function automatic int unsigned region_depth(input fb_mode_e m, input int unsigned base_depth);
        case (m)
            MODE_ST, MODE_SMT2: return base_depth;
            MODE_SMT4:          return base_depth / 2;
            default:            return base_depth / 4;
        endcase
    endfunction

    // Number of threads active in a given mode.
    function automatic int unsigned thread_span(input fb_mode_e m);
        return 32'd1 << m;
    endfunction

endpackage

// File: rtl/smt_fb_ctrl.sv
// Mode register, mode-change gating, inactive-tag error pulse and prefetch enable.
// Assumes all_empty_i is the AND of every thread's empty flag.
module smt_fb_ctrl
    import smt_fb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fb_mode_e         mode_req_i,
    input  logic             mode_req_vld_i,
    input  logic             all_empty_i,
    input  logic             wr_vld_i,
    input  logic [TID_W-1:0] wr_tid_i,
    output fb_mode_e         mode_o,
    output logic             mode_upd_o,
    output logic             wr_err_o,
    output logic             prefetch_en_o
);

    logic tid_bad;

    // Decide whether a mode request may be taken and whether a write tag is illegal.
    always_comb begin
        mode_upd_o    = mode_req_vld_i && all_empty_i && !wr_vld_i;
        tid_bad       = wr_vld_i && (32'(wr_tid_i) >= thread_span(mode_o));
        prefetch_en_o = (mode_o != MODE_SMT8);
    end

    // Hold the current mode and register the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o   <= MODE_ST;
            wr_err_o <= 1'b0;
        end else begin
            if (mode_upd_o) begin
                mode_o <= mode_req_i;
            end
            wr_err_o <= tid_bad;
        end
    end

    // R9
    mode_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req_vld_i && !all_empty_i) |=> $stable(mode_o));

    // R9
    mode_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_req_vld_i |=> $stable(mode_o));

    // R6
    err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |-> $past(wr_vld_i));

endmodule

// File: rtl/smt_fb_thread.sv
// One thread's circular queue bookkeeping: head, tail and count inside a
// private region whose base and size follow the mode. Assumes clear_i is only
// raised while the queue is empty.
module smt_fb_thread
    import smt_fb_pkg::*;
#(
    parameter  int unsigned TID        = 0,
    parameter  int unsigned BASE_DEPTH = 64,
    localparam int unsigned PTR_W      = $clog2(BASE_DEPTH),
    localparam int unsigned CNT_W      = PTR_W + 1,
    localparam int unsigned ADDR_W     = $clog2(2 * BASE_DEPTH)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  fb_mode_e          mode_i,
    input  logic              clear_i,
    input  logic              req_wr_i,
    input  logic              req_rd_i,
    output logic              active_o,
    output logic              push_o,
    output logic              full_o,
    output logic              empty_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o
);

    logic [CNT_W-1:0]  depth;
    logic [PTR_W-1:0]  last;
    logic [ADDR_W-1:0] base;
    logic [PTR_W-1:0]  head_q, tail_q;
    logic              do_pop;

    // Derive region size, base offset, status and accepted operations.
    always_comb begin
        depth     = CNT_W'(region_depth(mode_i, BASE_DEPTH));
        last      = PTR_W'(depth - CNT_W'(1));
        base      = ADDR_W'(TID * region_depth(mode_i, BASE_DEPTH));
        active_o  = (TID < thread_span(mode_i));
        full_o    = active_o && (count_o == depth);
        empty_o   = (count_o == '0);
        push_o    = req_wr_i && active_o && !full_o;
        do_pop    = req_rd_i && active_o && !empty_o;
        wr_addr_o = base + ADDR_W'(tail_q);
        rd_addr_o = base + ADDR_W'(head_q);
    end

    // Advance pointers with wrap at the region end and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_o <= '0;
        end else if (clear_i) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_o <= '0;
        end else begin
            if (push_o) begin
                tail_q <= (tail_q == last) ? '0 : tail_q + PTR_W'(1);
            end
            if (do_pop) begin
                head_q <= (head_q == last) ? '0 : head_q + PTR_W'(1);
            end
            case ({push_o, do_pop})
                2'b10:   count_o <= count_o + CNT_W'(1);
                2'b01:   count_o <= count_o - CNT_W'(1);
                default: count_o <= count_o;
            endcase
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !req_rd_i && !clear_i) |=> (count_o == $past(count_o)));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !req_wr_i) |=> empty_o);

    // R8
    rw_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr_i && req_rd_i && !full_o && !empty_o && !clear_i) |=> $stable(count_o));

    // R11
    idle_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (empty_o && !full_o));

    // R2
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= depth);

endmodule

// File: rtl/smt_fb_store.sv
// Shared instruction word array: one write port, one show-ahead read port per thread.
// Assumes at most one write per cycle and addresses already mapped to regions.
module smt_fb_store #(
    parameter  int unsigned WORD_W  = 32,
    parameter  int unsigned ENTRIES = 128,
    parameter  int unsigned NUM_RD  = 8,
    localparam int unsigned ADDR_W  = $clog2(ENTRIES)
)(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              wr_addr_i,
    input  logic [WORD_W-1:0]              wr_data_i,
    input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_i,
    output logic [NUM_RD-1:0][WORD_W-1:0]  rd_data_o
);

    logic [WORD_W-1:0] mem [ENTRIES];

    // Store the accepted instruction word.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    // Present each thread's head entry combinationally.
    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        assign rd_data_o[g] = mem[rd_addr_i[g]];
    end

    // R3
    wr_addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> !$isunknown(wr_addr_i));

endmodule

// File: rtl/smt_fetch_buf.sv
// Top of the thread-partitioned fetch buffer. Steers tagged writes to one
// thread queue, maps per-thread pointers onto the shared array and exposes
// per-thread status. Assumes the mode only changes while all queues are empty.
module smt_fetch_buf
    import smt_fb_pkg::*;
#(
    parameter  int unsigned WORD_W     = 32,
    parameter  int unsigned BASE_DEPTH = 64,
    localparam int unsigned CNT_W      = $clog2(BASE_DEPTH) + 1
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode_req_i,
    input  logic                      mode_req_vld_i,
    output logic [1:0]                mode_o,
    output logic                      prefetch_en_o,
    input  logic                      wr_vld_i,
    input  logic [2:0]                wr_tid_i,
    input  logic [WORD_W-1:0]         wr_data_i,
    output logic                      wr_err_o,
    input  logic [7:0]                rd_en_i,
    output logic [8*WORD_W-1:0]       rd_data_o,
    output logic [7:0]                full_o,
    output logic [7:0]                empty_o,
    output logic [8*CNT_W-1:0]        count_o
);

    localparam int unsigned ENTRIES = 2 * BASE_DEPTH;
    localparam int unsigned ADDR_W  = $clog2(ENTRIES);

    fb_mode_e                          mode_q;
    logic                              mode_upd;
    logic [THR_MAX-1:0]                thr_active;
    logic [THR_MAX-1:0]                thr_push;
    logic [THR_MAX-1:0][ADDR_W-1:0]    thr_wr_addr;
    logic [THR_MAX-1:0][ADDR_W-1:0]    thr_rd_addr;
    logic [THR_MAX-1:0][WORD_W-1:0]    rd_words;
    logic                              all_empty;

    smt_fb_ctrl i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_req_i     (fb_mode_e'(mode_req_i)),
        .mode_req_vld_i (mode_req_vld_i),
        .all_empty_i    (all_empty),
        .wr_vld_i       (wr_vld_i),
        .wr_tid_i       (wr_tid_i),
        .mode_o         (mode_q),
        .mode_upd_o     (mode_upd),
        .wr_err_o       (wr_err_o),
        .prefetch_en_o  (prefetch_en_o)
    );

    for (genvar g = 0; g < THR_MAX; g++) begin : g_thr
        logic req_wr;
        assign req_wr = wr_vld_i && (wr_tid_i == TID_W'(g));

        smt_fb_thread #(
            .TID        (g),
            .BASE_DEPTH (BASE_DEPTH)
        ) i_thread (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_i    (mode_q),
            .clear_i   (mode_upd),
            .req_wr_i  (req_wr),
            .req_rd_i  (rd_en_i[g]),
            .active_o  (thr_active[g]),
            .push_o    (thr_push[g]),
            .full_o    (full_o[g]),
            .empty_o   (empty_o[g]),
            .count_o   (count_o[g*CNT_W +: CNT_W]),
            .wr_addr_o (thr_wr_addr[g]),
            .rd_addr_o (thr_rd_addr[g])
        );
    end

    smt_fb_store #(
        .WORD_W  (WORD_W),
        .ENTRIES (ENTRIES),
        .NUM_RD  (THR_MAX)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (|thr_push),
        .wr_addr_i (thr_wr_addr[wr_tid_i]),
        .wr_data_i (wr_data_i),
        .rd_addr_i (thr_rd_addr),
        .rd_data_o (rd_words)
    );

    // Flatten outputs and summarise emptiness for the mode gate.
    always_comb begin
        mode_o    = mode_q;
        rd_data_o = rd_words;
        all_empty = &empty_o;
    end

    // R4
    single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(thr_push));

    // R10
    prefetch_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prefetch_en_o == !thr_active[THR_MAX-1]);

    // R6
    bad_tag_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld_i && !thr_active[wr_tid_i]) |=> wr_err_o);

endmodule

// File: tb/test_smt_fetch_buf.sv
// Directed bench for the thread-partitioned fetch buffer.
module test_smt_fetch_buf;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 32;
    localparam int CNT_W      = 7;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [1:0]           mode_req;
    logic                 mode_req_vld;
    logic [1:0]           mode;
    logic                 prefetch_en;
    logic                 wr_vld;
    logic [2:0]           wr_tid;
    logic [WORD_W-1:0]    wr_data;
    logic                 wr_err;
    logic [7:0]           rd_en;
    logic [8*WORD_W-1:0]  rd_data;
    logic [7:0]           full;
    logic [7:0]           empty;
    logic [8*CNT_W-1:0]   count;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smt_fetch_buf i_smt_fetch_buf (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_req_i     (mode_req),
        .mode_req_vld_i (mode_req_vld),
        .mode_o         (mode),
        .prefetch_en_o  (prefetch_en),
        .wr_vld_i       (wr_vld),
        .wr_tid_i       (wr_tid),
        .wr_data_i      (wr_data),
        .wr_err_o       (wr_err),
        .rd_en_i        (rd_en),
        .rd_data_o      (rd_data),
        .full_o         (full),
        .empty_o        (empty),
        .count_o        (count)
    );

    function automatic logic [31:0] mk(input int t, input int i);
        return {8'(t), 24'(i)};
    endfunction

    function automatic logic [CNT_W-1:0] cnt(input int t);
        return count[t*CNT_W +: CNT_W];
    endfunction

    function automatic logic [WORD_W-1:0] head(input int t);
        return rd_data[t*WORD_W +: WORD_W];
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input int t, input logic [31:0] d);
        wr_vld = 1'b1; wr_tid = 3'(t); wr_data = d;
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    task automatic do_read(input int t);
        rd_en[t] = 1'b1;
        @(negedge clk);
        rd_en = '0;
    endtask

    task automatic set_mode(input int m);
        mode_req = 2'(m); mode_req_vld = 1'b1;
        @(negedge clk);
        mode_req_vld = 1'b0;
    endtask

    task automatic fill(input int t, input int n, input int first);
        for (int i = 0; i < n; i++) do_write(t, mk(t, first + i));
    endtask

    task automatic drain(input string req, input int t, input int n, input int first);
        for (int i = 0; i < n; i++) begin
            chk(req, "head word", 64'(head(t)), 64'(mk(t, first + i)));
            do_read(t);
        end
        chk(req, "empty after drain", 64'(empty[t]), 64'(1));
    endtask

    task automatic t_reset();
        chk("R1", "mode", 64'(mode), 64'(0));
        chk("R1", "empty flags", 64'(empty), 64'hFF);
        chk("R1", "full flags", 64'(full), 64'h00);
        chk("R1", "counts", 64'(count), 64'(0));
        chk("R1", "prefetch", 64'(prefetch_en), 64'(1));
        chk("R1", "error", 64'(wr_err), 64'(0));
    endtask

    task automatic t_single();
        fill(0, 64, 0);
        chk("R2", "single count", 64'(cnt(0)), 64'(64));
        chk("R2", "single full", 64'(full[0]), 64'(1));
        do_write(0, 32'hDEAD_BEEF);
        chk("R5", "count after overfill", 64'(cnt(0)), 64'(64));
        do_write(1, mk(1, 7));
        chk("R6", "error pulse", 64'(wr_err), 64'(1));
        chk("R11", "thread1 empty", 64'(empty[1]), 64'(1));
        @(negedge clk);
        chk("R6", "error cleared", 64'(wr_err), 64'(0));
        drain("R5", 0, 64, 0);
        do_read(0);
        chk("R7", "count after empty read", 64'(cnt(0)), 64'(0));
        do_write(0, mk(0, 500));
        chk("R7", "count after refill", 64'(cnt(0)), 64'(1));
        drain("R7", 0, 1, 500);
    endtask

    task automatic t_mode_gate();
        do_write(0, mk(0, 1));
        set_mode(2);
        chk("R9", "mode kept while busy", 64'(mode), 64'(0));
        drain("R9", 0, 1, 1);
        wr_vld = 1'b1; wr_tid = 3'd0; wr_data = mk(0, 2);
        mode_req = 2'd3; mode_req_vld = 1'b1;
        @(negedge clk);
        wr_vld = 1'b0; mode_req_vld = 1'b0;
        chk("R9", "mode kept with write", 64'(mode), 64'(0));
        chk("R9", "write taken", 64'(cnt(0)), 64'(1));
        drain("R9", 0, 1, 2);
        set_mode(1);
        chk("R9", "mode accepted", 64'(mode), 64'(1));
        chk("R10", "prefetch mode1", 64'(prefetch_en), 64'(1));
    endtask

    task automatic t_isolation();
        fill(1, 64, 0);
        chk("R2", "thread1 full at 64", 64'(full[1]), 64'(1));
        fill(0, 3, 100);
        chk("R4", "thread0 count", 64'(cnt(0)), 64'(3));
        chk("R4", "thread0 not full", 64'(full[0]), 64'(0));
        chk("R11", "thread2 idle", 64'({full[2], empty[2]}), 64'(1));
        drain("R4", 0, 3, 100);
        drain("R4", 1, 64, 0);
    endtask

    task automatic t_four();
        set_mode(2);
        chk("R9", "mode 2", 64'(mode), 64'(2));
        fill(2, 32, 0);
        chk("R2", "thread2 full at 32", 64'(full[2]), 64'(1));
        chk("R2", "thread2 count", 64'(cnt(2)), 64'(32));
        do_write(3, mk(3, 9));
        chk("R4", "thread3 count", 64'(cnt(3)), 64'(1));
        do_write(4, mk(4, 0));
        chk("R6", "tag 4 error", 64'(wr_err), 64'(1));
        chk("R11", "thread4 count", 64'(cnt(4)), 64'(0));
        drain("R2", 2, 32, 0);
        drain("R4", 3, 1, 9);
    endtask

    task automatic t_same_cycle();
        fill(3, 2, 0);
        rd_en[3] = 1'b1; wr_vld = 1'b1; wr_tid = 3'd3; wr_data = mk(3, 2);
        @(negedge clk);
        rd_en = '0; wr_vld = 1'b0;
        chk("R8", "count held", 64'(cnt(3)), 64'(2));
        drain("R8", 3, 2, 1);
    endtask

    task automatic t_eight_wrap();
        set_mode(3);
        chk("R10", "prefetch off", 64'(prefetch_en), 64'(0));
        fill(7, 10, 0);
        drain("R12", 7, 10, 0);
        fill(7, 16, 10);
        chk("R2", "thread7 full at 16", 64'(full[7]), 64'(1));
        do_write(7, mk(7, 99));
        chk("R12", "count after wrap fill", 64'(cnt(7)), 64'(16));
        do_write(0, mk(0, 55));
        chk("R4", "thread0 head", 64'(head(0)), 64'(mk(0, 55)));
        drain("R12", 7, 16, 10);
        drain("R4", 0, 1, 55);
        set_mode(0);
        chk("R10", "prefetch back on", 64'(prefetch_en), 64'(1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_req = '0; mode_req_vld = 1'b0;
        wr_vld = 1'b0; wr_tid = '0; wr_data = '0; rd_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_mode_gate();
        t_isolation();
        t_four();
        t_same_cycle();
        t_eight_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule